// File: doc/BRIEF.md
# Spare Block Buffer for Faulty Cache Lines

This block is a small fully associative store that sits next to a primary cache whose defective lines have been switched off. Every block address whose home line in the primary cache is flagged as faulty is served from here instead. The primary controller presents each access together with a faulty-home flag. Only flagged accesses are looked up. On a hit the block data comes back in the same cycle. On a miss the buffer claims an entry, writes back a dirty victim if one must be evicted, and then fetches the missing block from the next level. After that the controller retries the access.

Only blocks that map to faulty lines compete for the entries. When more such blocks are live than there are entries, least-recently-used replacement decides which block leaves. A block is 16 bytes. Writes follow the primary cache's write-back, write-allocate policy: a write hit updates the whole block and marks it dirty, and a write miss allocates first and completes on the retry. The entry count is a parameter and may be 2, 4 or 8. The block is the same for a direct-mapped, 2-way or 4-way primary cache.

Top module: `spare_blk_buf`

## Requirements
- R1: After reset no entry is valid, `ready_o` is 1, and `hit_o`, `fill_req_o` and `wb_valid_o` are 0.
- R2: `hit_o` is 1 in the same cycle as a request only when `req_valid_i`, `req_faulty_i` and `ready_o` are all 1 and a valid entry holds `req_addr_i`. At that time `rdata_o` carries the entry's block.
- R3: A request with `req_faulty_i` at 0 never hits, even if its address is held. It allocates nothing: `ready_o` stays 1 and no fill or writeback starts.
- R4: A faulty request that misses drops `ready_o` at the next edge and raises `fill_req_o` with `fill_addr_o` equal to the missed address once any writeback is done. The cycle with `fill_valid_i` at 1 installs the block clean and returns `ready_o` to 1 at the next edge. A later lookup of that address hits with the filled data.
- R5: A write hit (`req_we_i` at 1) replaces the entry's block with `req_wdata_i` and marks it dirty. A later read returns the new data.
- R6: The entry to replace is the lowest-indexed invalid entry. If all entries are valid, it is the entry least recently hit or filled.
- R7: If the chosen entry is valid and dirty, `wb_valid_o` is raised with that entry's address and data before any fill request, and the fill request follows the cycle after `wb_ready_i`. A clean or invalid entry causes no writeback.
- R8: While `wb_valid_o` waits for `wb_ready_i`, `wb_addr_o` and `wb_data_o` stay stable. While `fill_req_o` waits for `fill_valid_i`, `fill_addr_o` stays stable.
- R9: No address is ever held in two valid entries at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request from the primary controller |
| req_faulty_i | input | 1 | Home line of the address is disabled as faulty |
| req_we_i | input | 1 | Access is a block write |
| req_addr_i | input | ADDR_W | Block address |
| req_wdata_i | input | BLK_W | Write data, a full block |
| ready_o | output | 1 | Buffer idle and accepting lookups |
| hit_o | output | 1 | Faulty-home access found in the buffer |
| rdata_o | output | BLK_W | Block data of the hit entry |
| fill_req_o | output | 1 | Request for the missed block from the next level |
| fill_addr_o | output | ADDR_W | Address being fetched |
| fill_valid_i | input | 1 | Fill data present |
| fill_data_i | input | BLK_W | Fill block |
| wb_valid_o | output | 1 | Dirty victim to be written back |
| wb_addr_o | output | ADDR_W | Victim address |
| wb_data_o | output | BLK_W | Victim block |
| wb_ready_i | input | 1 | Writeback accepted |

## Verification
Internal errors in this block appear at the ports only later. A corrupt replacement order, a lost dirty bit or a duplicated tag shows up when a later miss evicts an entry. The wrong victim then appears on `wb_addr_o`, a writeback is missing, or an access misses that should have hit. This can happen many accesses after the fault. The bench therefore keeps an independent record of entry contents and use times. It drives a small pool of addresses that is larger than the buffer, so evictions happen often. Every hit, writeback and fill is compared with that record as it occurs, so a divergence is caught at the first eviction or lookup that depends on it.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } sb_state_e;
endpackage

// File: rtl/sb_tag_match.sv
module sb_tag_match #(
  parameter int N      = 4,
  parameter int ADDR_W = 28,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N-1:0][ADDR_W-1:0]   tags_i,
  input  logic [N-1:0]               valid_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic                       hit_any_o,
  output logic [IDX_W-1:0]           hit_idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == addr_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int j = 0; j < N; j++)
      if (match[j]) hit_idx_o = IDX_W'(j);
  end

  assign hit_any_o = |match;

  // R9: no duplicate tags among valid entries
  a_r9_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/sb_lru.sv
module sb_lru #(
  parameter int N      = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [N-1:0]     valid_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [N-1:0][IDX_W-1:0] age_q;
  logic [N-1:0]            oldest;
  logic                    found;

  // age 0 = most recent, N-1 = least recent; ages stay a permutation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < N; j++) age_q[j] <= IDX_W'(j);
    end else if (touch_i) begin
      for (int j = 0; j < N; j++) begin
        if (IDX_W'(j) == touch_idx_i)         age_q[j] <= '0;
        else if (age_q[j] < age_q[touch_idx_i]) age_q[j] <= age_q[j] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest[g] = (age_q[g] == IDX_W'(N-1));
  end

  always_comb begin
    victim_o = '0;
    found    = 1'b0;
    for (int j = 0; j < N; j++)
      if (!valid_i[j] && !found) begin
        victim_o = IDX_W'(j);
        found    = 1'b1;
      end
    if (!found)
      for (int j = 0; j < N; j++)
        if (oldest[j]) victim_o = IDX_W'(j);
  end

  // R6: exactly one least-recent entry exists
  a_r6_one_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest) == 1);
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      miss_i,
  input  logic      victim_dirty_i,
  input  logic      wb_ready_i,
  input  logic      fill_valid_i,
  output sb_state_e state_o,
  output logic      fill_done_o
);
  sb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (miss_i) state_d = victim_dirty_i ? ST_WB : ST_FILL;
      ST_WB:   if (wb_ready_i) state_d = ST_FILL;
      ST_FILL: if (fill_valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign fill_done_o = (state_q == ST_FILL) && fill_valid_i;

  // R7: writeback never leads straight back to idle
  a_r7_wb_precedes_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/spare_blk_buf.sv
module spare_blk_buf
  import sb_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 28,
  parameter int BLK_W  = 128,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_faulty_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BLK_W-1:0]  req_wdata_i,
  output logic              ready_o,
  output logic              hit_o,
  output logic [BLK_W-1:0]  rdata_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_valid_i,
  input  logic [BLK_W-1:0]  fill_data_i,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [BLK_W-1:0]  wb_data_o,
  input  logic              wb_ready_i
);
  logic [N-1:0][ADDR_W-1:0] tag_q;
  logic [N-1:0][BLK_W-1:0]  data_q;
  logic [N-1:0]             valid_q, dirty_q;
  logic [IDX_W-1:0]         vic_idx_q, victim, hit_idx, touch_idx;
  logic [ADDR_W-1:0]        miss_addr_q;
  logic                     hit_any, lookup, miss, fill_done, touch;
  sb_state_e                state;

  sb_tag_match #(.N(N), .ADDR_W(ADDR_W)) i_match (
    .clk_i, .rst_ni, .tags_i(tag_q), .valid_i(valid_q), .addr_i(req_addr_i),
    .hit_any_o(hit_any), .hit_idx_o(hit_idx));

  sb_lru #(.N(N)) i_lru (
    .clk_i, .rst_ni, .touch_i(touch), .touch_idx_i(touch_idx),
    .valid_i(valid_q), .victim_o(victim));

  sb_ctrl i_ctrl (
    .clk_i, .rst_ni, .miss_i(miss),
    .victim_dirty_i(valid_q[victim] && dirty_q[victim]),
    .wb_ready_i, .fill_valid_i, .state_o(state), .fill_done_o(fill_done));

  assign ready_o     = (state == ST_IDLE);
  assign lookup      = req_valid_i && req_faulty_i && ready_o;
  assign hit_o       = lookup && hit_any;
  assign miss        = lookup && !hit_any;
  assign rdata_o     = data_q[hit_idx];
  assign touch       = hit_o || fill_done;
  assign touch_idx   = fill_done ? vic_idx_q : hit_idx;
  assign wb_valid_o  = (state == ST_WB);
  assign wb_addr_o   = tag_q[vic_idx_q];
  assign wb_data_o   = data_q[vic_idx_q];
  assign fill_req_o  = (state == ST_FILL);
  assign fill_addr_o = miss_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vic_idx_q   <= '0;
      miss_addr_q <= '0;
    end else if (miss) begin
      vic_idx_q   <= victim;
      miss_addr_q <= req_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      tag_q   <= '0;
      data_q  <= '0;
    end else if (fill_done) begin
      valid_q[vic_idx_q] <= 1'b1;
      dirty_q[vic_idx_q] <= 1'b0;
      tag_q[vic_idx_q]   <= miss_addr_q;
      data_q[vic_idx_q]  <= fill_data_i;
    end else if (hit_o && req_we_i) begin
      dirty_q[hit_idx] <= 1'b1;
      data_q[hit_idx]  <= req_wdata_i;
    end
  end

  // R3: healthy-home traffic never leaves idle
  a_r3_no_alloc_healthy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !(req_valid_i && req_faulty_i)) |=> ready_o);
  // R5: write hit leaves the entry dirty with the written block
  a_r5_write_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && req_we_i) |=> (dirty_q[$past(hit_idx)] &&
                             data_q[$past(hit_idx)] == $past(req_wdata_i)));
  // R8: writeback payload held until accepted
  a_r8_wb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o)));
  // R8: fill address held until data arrives
  a_r8_fill_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> (fill_req_o && $stable(fill_addr_o)));
  // R4: a completed fill returns to idle
  a_r4_fill_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_valid_i) |=> ready_o);
endmodule

// File: tb/test_spare_blk_buf.sv
module test_spare_blk_buf;
  localparam int N = 4, AW = 28, BW = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_faulty = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_wdata = '0;
  logic ready, hit, fill_req, fill_valid = 0, wb_valid, wb_ready = 0;
  logic [BW-1:0] rdata, fill_data = '0, wb_data;
  logic [AW-1:0] fill_addr, wb_addr;

  int errors = 0, checks = 0, tick = 0;
  bit done = 0;

  logic [AW-1:0] m_tag [N];
  logic [BW-1:0] m_data [N];
  bit            m_valid [N], m_dirty [N];
  int            m_used [N];

  always #4 clk = ~clk;

  spare_blk_buf #(.N(N), .ADDR_W(AW), .BLK_W(BW)) i_spare_blk_buf (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_faulty_i(req_faulty),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ready_o(ready),
    .hit_o(hit), .rdata_o(rdata), .fill_req_o(fill_req), .fill_addr_o(fill_addr),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data), .wb_valid_o(wb_valid),
    .wb_addr_o(wb_addr), .wb_data_o(wb_data), .wb_ready_i(wb_ready));

  task automatic chk(bit ok, string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] rnd_blk();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic int find(logic [AW-1:0] a);
    for (int j = 0; j < N; j++) if (m_valid[j] && m_tag[j] == a) return j;
    return -1;
  endfunction

  function automatic int pick_victim();
    int v = 0;
    for (int j = 0; j < N; j++) if (!m_valid[j]) return j;
    for (int j = 1; j < N; j++) if (m_used[j] < m_used[v]) v = j;
    return v;
  endfunction

  task automatic access(logic [AW-1:0] a, bit we, bit faulty, logic [BW-1:0] wd);
    int idx = faulty ? find(a) : -1;
    @(negedge clk);
    req_valid = 1; req_faulty = faulty; req_we = we; req_addr = a; req_wdata = wd;
    #1;
    chk(hit == (idx >= 0), faulty ? "R2 hit flag" : "R3 healthy no hit", BW'(hit), BW'(idx >= 0));
    if (idx >= 0) chk(rdata == m_data[idx], "R2 hit data", rdata, m_data[idx]);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_faulty = 0; req_we = 0;
    #1;
    if (idx >= 0) begin
      tick++; m_used[idx] = tick;
      if (we) begin m_data[idx] = wd; m_dirty[idx] = 1; end
      chk(ready == 1, "R2 stays ready on hit", BW'(ready), 1);
    end else if (!faulty) begin
      chk(ready && !fill_req && !wb_valid, "R3 no allocation", BW'({ready, fill_req, wb_valid}), 4);
    end else begin
      int v = pick_victim();
      bit d = m_valid[v] && m_dirty[v];
      chk(ready == 0, "R4 busy after miss", BW'(ready), 0);
      chk(wb_valid == d, "R7 writeback when dirty", BW'(wb_valid), BW'(d));
      if (d) begin
        chk(!fill_req, "R7 no fill before writeback", BW'(fill_req), 0);
        chk(wb_addr == m_tag[v], "R6 victim address", BW'(wb_addr), BW'(m_tag[v]));
        chk(wb_data == m_data[v], "R7 victim data", wb_data, m_data[v]);
        repeat ($urandom_range(0, 3)) begin
          @(negedge clk); #1;
          chk(wb_valid && wb_addr == m_tag[v] && wb_data == m_data[v], "R8 writeback hold",
              BW'(wb_addr), BW'(m_tag[v]));
        end
        wb_ready = 1;
        @(posedge clk); @(negedge clk);
        wb_ready = 0; #1;
      end
      chk(fill_req == 1, "R4 fill request", BW'(fill_req), 1);
      chk(fill_addr == a, "R4 fill address", BW'(fill_addr), BW'(a));
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk); #1;
        chk(fill_req && fill_addr == a, "R8 fill hold", BW'(fill_addr), BW'(a));
      end
      @(negedge clk);
      fill_valid = 1; fill_data = rnd_blk();
      @(posedge clk); @(negedge clk);
      fill_valid = 0; #1;
      chk(ready == 1, "R4 ready after fill", BW'(ready), 1);
      tick++;
      m_tag[v] = a; m_data[v] = fill_data; m_valid[v] = 1; m_dirty[v] = 0; m_used[v] = tick;
    end
  endtask

  function automatic logic [AW-1:0] pool(int k);
    return AW'(28'h0100 + k * 28'h40);
  endfunction

  initial begin
    void'($urandom(32'd1357));
    for (int j = 0; j < N; j++) begin m_valid[j] = 0; m_dirty[j] = 0; m_used[j] = 0; end
    #1;
    chk(ready && !hit && !fill_req && !wb_valid, "R1 reset outputs",
        BW'({ready, hit, fill_req, wb_valid}), 8);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: empty after reset, first faulty access misses
    access(pool(0), 0, 1, '0);
    access(pool(0), 0, 1, '0);
    // R3: present address, healthy home -> no hit
    access(pool(0), 0, 0, '0);
    // R6: fill remaining invalid slots in order
    for (int k = 1; k < N; k++) access(pool(k), 0, 1, '0);
    // R5: write hit then read back
    access(pool(1), 1, 1, rnd_blk());
    access(pool(1), 0, 1, '0);
    // R6: refresh pool(0); LRU victim is pool(2)
    access(pool(0), 0, 1, '0);
    access(pool(7), 0, 1, '0);
    chk(find(pool(2)) < 0, "R6 LRU evicted", BW'(find(pool(2))), BW'(-1));
    access(pool(2), 0, 1, '0);
    // R7: dirty pool(1) eventually evicted with writeback
    for (int k = 8; k < 12; k++) access(pool(k), 0, 1, '0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a = pool($urandom_range(0, 9));
      bit f = ($urandom_range(0, 9) < 8);
      bit w = $urandom_range(0, 2) == 0;
      access(a, w, f, rnd_blk());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule